// File: doc/BRIEF.md
# Transceiver Reconfiguration Command Sequencer

This block is the control-side state machine that changes a transceiver's data rate through a reconfiguration management slave. It is a memory-mapped master with 32-bit data and 6-bit word offsets. A start pulse makes it run a fixed script of management writes for one logical channel. The script selects the channel, selects configuration-file streaming mode, stages the file base address and commits it, then stages the stream command and commits that. After the script, the block polls a busy flag until the slave reports that the operation is complete.

With the sweep input set at start, the block runs the script once for every reconfiguration interface, in ascending order. There are twice as many interfaces as lanes, because each lane has its own transmit PLL. Without sweep, it handles only the channel given at start. A programmable limit bounds the busy wait. When the limit is exceeded, the block abandons the operation and reports an error together with its done pulse.

Top module: `rcfg_seq`

## Requirements
- R1: The first write for each channel goes to offset 0x38 with the channel number in bits [9:0] and zeros above.
- R2: The second write goes to offset 0x3A with value 0. This sets the mode field [3:2] to 2'b00 (file streaming) and leaves commit bit [0] clear.
- R3: Writes three to five are, in order: 0 to offset 0x3B, the base address (parameter, default 32'h1000) to offset 0x3C, and 1 to offset 0x3A (commit).
- R4: Writes six to eight are, in order: 1 to offset 0x3B, 3 to offset 0x3C, and 1 to offset 0x3A. No other write occurs, so each channel costs exactly eight writes.
- R5: After the eighth write, the block reads offset 0x3A repeatedly, one read outstanding at a time. A read with bit [8] = 1 means busy. A read with bit [8] = 0 ends the channel. All other read bits are ignored.
- R6: With sweep_i = 1 at start, channels 0 to 2*LANES-1 are processed in ascending order. With sweep_i = 0, only chan_i is processed.
- R7: While waitrequest is high, an issued read or write stays asserted with stable address and write data. Read and write are never asserted together.
- R8: With poll limit L (captured at start), L busy reads are tolerated. The (L+1)th consecutive busy read on a channel ends the whole run, and err_o pulses together with done_o.
- R9: busy_o is high from the cycle after an accepted start until the run ends. done_o pulses for one cycle as busy_o falls, and err_o is never high without done_o.
- R10: A start pulse while busy_o is high has no effect on the run or on the writes issued.
- R11: After reset, busy_o, done_o, err_o, av_write and av_read are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| sweep_i | input | 1 | Sampled at start: 1 processes every interface |
| chan_i | input | CHAN_W | Sampled at start: channel for a single run |
| poll_limit_i | input | POLL_W | Sampled at start: number of tolerated busy reads |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle poll timeout pulse, coincident with done_o |
| av_address | output | ADDR_W | Management word offset |
| av_write | output | 1 | Write request |
| av_writedata | output | DATA_W | Write data |
| av_read | output | 1 | Read request |
| av_waitrequest | input | 1 | Slave stall |
| av_readdata | input | DATA_W | Read data |
| av_readdatavalid | input | 1 | Read data strobe |

## Verification
The bound checker checks the bus rules on every cycle: held requests under waitrequest, exclusive read and write, reads only at the control offset, and writes only at the four script offsets. It also checks the relation of busy_o, done_o and err_o to each other and to start_i. The exact write order and data, the poll count against the limit, the sweep channel order and the ignored restart can only be shown by the bench. The bench runs a slave model that counts down a chosen number of busy replies. It sweeps channels, busy counts and limits, with and without random stalls, and compares every logged transfer against the script it computes itself.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_WAIT  = 2'd3
   } seq_state_t;

   localparam int unsigned OFS_W    = 6;
   localparam logic [OFS_W-1:0] OFS_CHAN = 6'h38;
   localparam logic [OFS_W-1:0] OFS_CTRL = 6'h3A;
   localparam logic [OFS_W-1:0] OFS_SOFF = 6'h3B;
   localparam logic [OFS_W-1:0] OFS_SDAT = 6'h3C;
   localparam int unsigned BUSY_BIT = 8;
   localparam int unsigned N_STEPS  = 8;
   localparam int unsigned STEP_W   = $clog2(N_STEPS);
   localparam int unsigned STREAM_CMD = 3;
endpackage

// File: rtl/rcfg_script.sv
module rcfg_script
   import rcfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CHAN_W = 10,
   parameter logic [31:0] BASE_ADDR = 32'h1000
) (
   input  logic [STEP_W-1:0] step_i,
   input  logic [CHAN_W-1:0] chan_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      addr_o = ADDR_W'(OFS_CTRL);
      data_o = '0;
      unique case (step_i)
         3'd0: begin addr_o = ADDR_W'(OFS_CHAN); data_o = DATA_W'(chan_i);     end
         3'd1: begin addr_o = ADDR_W'(OFS_CTRL); data_o = '0;                  end
         3'd2: begin addr_o = ADDR_W'(OFS_SOFF); data_o = '0;                  end
         3'd3: begin addr_o = ADDR_W'(OFS_SDAT); data_o = DATA_W'(BASE_ADDR);  end
         3'd4: begin addr_o = ADDR_W'(OFS_CTRL); data_o = DATA_W'(1);          end
         3'd5: begin addr_o = ADDR_W'(OFS_SOFF); data_o = DATA_W'(1);          end
         3'd6: begin addr_o = ADDR_W'(OFS_SDAT); data_o = DATA_W'(STREAM_CMD); end
         default: begin addr_o = ADDR_W'(OFS_CTRL); data_o = DATA_W'(1);       end
      endcase
   end
endmodule

// File: rtl/rcfg_poll_timer.sv
module rcfg_poll_timer #(
   parameter int unsigned POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              bump_i,
   input  logic [POLL_W-1:0] limit_i,
   output logic              hit_o
);
   logic [POLL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (bump_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/rcfg_chan_ctr.sv
module rcfg_chan_ctr #(
   parameter int unsigned CHAN_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CHAN_W-1:0] first_i,
   input  logic [CHAN_W-1:0] last_i,
   input  logic              adv_i,
   output logic [CHAN_W-1:0] chan_o,
   output logic              at_last_o
);
   logic [CHAN_W-1:0] chan_q, last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q <= '0;
         last_q <= '0;
      end else if (load_i) begin
         chan_q <= first_i;
         last_q <= last_i;
      end else if (adv_i) begin
         chan_q <= chan_q + 1'b1;
      end
   end

   assign chan_o    = chan_q;
   assign at_last_o = (chan_q == last_q);
endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq
   import rcfg_pkg::*;
#(
   parameter int unsigned LANES     = 2,
   parameter int unsigned CHAN_W    = 10,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned POLL_W    = 16,
   parameter logic [31:0] BASE_ADDR = 32'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sweep_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic [POLL_W-1:0] poll_limit_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] av_address,
   output logic              av_write,
   output logic [DATA_W-1:0] av_writedata,
   output logic              av_read,
   input  logic              av_waitrequest,
   input  logic [DATA_W-1:0] av_readdata,
   input  logic              av_readdatavalid
);
   localparam int unsigned N_IF = 2 * LANES;
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);
   localparam logic [CHAN_W-1:0] IF_LAST   = CHAN_W'(N_IF - 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("rcfg_seq: LANES must be at least 1");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("rcfg_seq: ADDR_W too narrow for the management offsets");
   end
   if (DATA_W < BUSY_BIT + 1 || DATA_W < CHAN_W) begin : g_bad_data
      $error("rcfg_seq: DATA_W too narrow");
   end
   if (N_IF > (1 << CHAN_W)) begin : g_bad_chan
      $error("rcfg_seq: CHAN_W cannot number every interface");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("rcfg_seq: POLL_W must be at least 1");
   end

   seq_state_t        state_q;
   logic [STEP_W-1:0] step_q;
   logic [POLL_W-1:0] limit_q;
   logic              done_q, err_q;

   logic [CHAN_W-1:0] chan;
   logic              at_last, lim_hit, rd_busy, rd_beat;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;
   logic              unused_rd;

   assign unused_rd = ^av_readdata;
   assign rd_beat   = (state_q == ST_WAIT) && av_readdatavalid;
   assign rd_busy   = av_readdata[BUSY_BIT];

   rcfg_script #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .BASE_ADDR(BASE_ADDR)
   ) u_script (
      .step_i(step_q), .chan_i(chan), .addr_o(s_addr), .data_o(s_data)
   );

   rcfg_chan_ctr #(.CHAN_W(CHAN_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   ((state_q == ST_IDLE) && start_i),
      .first_i  (sweep_i ? '0 : chan_i),
      .last_i   (sweep_i ? IF_LAST : chan_i),
      .adv_i    (rd_beat && !rd_busy && !at_last),
      .chan_o   (chan),
      .at_last_o(at_last)
   );

   rcfg_poll_timer #(.POLL_W(POLL_W)) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i((state_q == ST_WRITE) && !av_waitrequest && (step_q == STEP_LAST)),
      .bump_i (rd_beat && rd_busy && !lim_hit),
      .limit_i(limit_q),
      .hit_o  (lim_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         limit_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_WRITE;
               step_q  <= '0;
               limit_q <= poll_limit_i;
            end
            ST_WRITE: if (!av_waitrequest) begin
               if (step_q == STEP_LAST) state_q <= ST_READ;
               else                     step_q  <= step_q + 1'b1;
            end
            ST_READ: if (!av_waitrequest) state_q <= ST_WAIT;
            ST_WAIT: if (av_readdatavalid) begin
               if (!rd_busy) begin
                  if (at_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_WRITE;
                     step_q  <= '0;
                  end
               end else if (lim_hit) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= 1'b1;
               end else begin
                  state_q <= ST_READ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign av_write     = (state_q == ST_WRITE);
   assign av_read      = (state_q == ST_READ);
   assign av_address   = av_write ? s_addr : ADDR_W'(OFS_CTRL);
   assign av_writedata = av_write ? s_data : '0;
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = done_q;
   assign err_o        = err_q;
endmodule

// File: rtl/rcfg_seq_chk.sv
module rcfg_seq_chk
   import rcfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              av_write,
   input logic              av_read,
   input logic              av_waitrequest,
   input logic [ADDR_W-1:0] av_address,
   input logic [DATA_W-1:0] av_writedata
);
   assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      av_write && av_waitrequest |=> av_write && $stable(av_address) && $stable(av_writedata));

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      av_read && av_waitrequest |=> av_read && $stable(av_address));

   assert_rw_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(av_read && av_write));

   assert_rd_ofs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      av_read |-> av_address == ADDR_W'(OFS_CTRL));

   assert_wr_ofs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      av_write |-> (av_address == ADDR_W'(OFS_CHAN) || av_address == ADDR_W'(OFS_CTRL) ||
                    av_address == ADDR_W'(OFS_SOFF) || av_address == ADDR_W'(OFS_SDAT)));

   assert_err_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && $past(busy_o));

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !av_write && !av_read);
endmodule

bind rcfg_seq rcfg_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
   .err_o(err_o), .av_write(av_write), .av_read(av_read), .av_waitrequest(av_waitrequest),
   .av_address(av_address), .av_writedata(av_writedata)
);

// File: tb/rcfg_seq_tb.sv
module rcfg_seq_tb;
   localparam int LANES = 2;
   localparam int N_IF  = 2 * LANES;
   localparam logic [31:0] BASE = 32'h1000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 1'b0, sweep_i = 1'b0;
   logic [9:0]  chan_i = '0;
   logic [15:0] poll_limit_i = '0;
   logic        busy_o, done_o, err_o;
   logic [5:0]  av_address;
   logic        av_write, av_read;
   logic [31:0] av_writedata;
   logic        av_waitrequest = 1'b0;
   logic [31:0] av_readdata = '0;
   logic        av_readdatavalid = 1'b0;

   always #10 clk = ~clk;

   rcfg_seq #(.LANES(LANES)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sweep_i(sweep_i), .chan_i(chan_i),
      .poll_limit_i(poll_limit_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .av_address(av_address), .av_write(av_write), .av_writedata(av_writedata),
      .av_read(av_read), .av_waitrequest(av_waitrequest), .av_readdata(av_readdata),
      .av_readdatavalid(av_readdatavalid)
   );

   int n_chk = 0, n_bad = 0;
   logic [5:0]  log_a [0:127];
   logic [31:0] log_d [0:127];
   int nw = 0, nr = 0, ndone = 0, nerr = 0;
   int busy_polls = 0, busy_left = 0;
   bit stall_en = 0, pend = 0;
   logic [31:0] pend_data = '0, soff = '0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // slave model: all decisions taken at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         av_readdatavalid = pend;
         av_readdata      = pend ? pend_data : 32'hDEAD_BEEF;
         pend             = 0;
         av_waitrequest   = stall_en & lfsr[0] & lfsr[2];
         if (done_o) ndone++;
         if (err_o)  nerr++;
         #1;
         if (av_write && !av_waitrequest) begin
            if (nw < 128) begin
               log_a[nw] = av_address;
               log_d[nw] = av_writedata;
            end
            nw++;
            if (av_address == 6'h3B) soff = av_writedata;
            if (av_address == 6'h3A && av_writedata[0] && soff == 1) busy_left = busy_polls;
         end
         if (av_read && !av_waitrequest) begin
            nr++;
            pend = 1;
            pend_data = (busy_left != 0) ? 32'h0000_0100 : 32'hFFFF_FEFF;
            if (busy_left > 0) busy_left--;
         end
      end
   end

   function automatic logic [5:0] exp_a(input int s);
      case (s)
         0: exp_a = 6'h38;
         2, 5: exp_a = 6'h3B;
         3, 6: exp_a = 6'h3C;
         default: exp_a = 6'h3A;
      endcase
   endfunction

   function automatic logic [31:0] exp_d(input int s, input int ch);
      case (s)
         0: exp_d = 32'(ch);
         1, 2: exp_d = 0;
         3: exp_d = BASE;
         6: exp_d = 3;
         default: exp_d = 1;
      endcase
   endfunction

   task automatic launch(input int ch, input bit sw, input int lim, input int polls);
      nw = 0; nr = 0; ndone = 0; nerr = 0;
      busy_polls = polls; busy_left = 0;
      @(negedge clk);
      start_i = 1; sweep_i = sw; chan_i = 10'(ch); poll_limit_i = 16'(lim);
      @(negedge clk);
      start_i = 0;
      #3;
      chk(busy_o == 1, "R9", "busy after start", busy_o, 1);
   endtask

   task automatic await_done();
      int k;
      for (k = 0; k < 4000; k++) begin
         @(negedge clk); #3;
         if (ndone > 0) break;
      end
      chk(k < 4000, "R9", "watchdog run completion", k, 0);
      repeat (3) @(negedge clk);
      #3;
   endtask

   task automatic run_check(input int ch, input bit sw, input int lim, input int polls);
      int first, nch, exp_w, exp_r, miss;
      bit to;
      launch(ch, sw, lim, polls);
      await_done();
      first = sw ? 0 : ch;
      to    = polls > lim;
      nch   = to ? 1 : (sw ? N_IF : 1);
      exp_w = 8 * nch;
      exp_r = to ? lim + 1 : nch * (polls + 1);
      chk(nw == exp_w, "R4", "write count", nw, exp_w);
      miss = 0;
      for (int i = 0; i < nw && i < 128; i++) begin
         if (log_a[i] != exp_a(i % 8) || log_d[i] != exp_d(i % 8, first + i / 8)) miss++;
      end
      chk(miss == 0, sw ? "R6" : "R1", "script mismatches (R1 R2 R3 R4)", miss, 0);
      chk(nr == exp_r, to ? "R8" : "R5", "poll reads", nr, exp_r);
      chk(ndone == 1, "R9", "done pulses", ndone, 1);
      chk(nerr == int'(to), "R8", "error pulses", nerr, int'(to));
      chk(busy_o == 0, "R9", "idle after done", busy_o, 0);
   endtask

   initial begin
      #(200000 * 20);
      chk(0, "R9", "global watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int chans [4] = '{0, 1, 513, 1023};
      repeat (3) @(negedge clk);
      #3;
      chk(busy_o == 0 && done_o == 0 && err_o == 0, "R11", "outputs in reset",
          {busy_o, done_o, err_o}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      #3;
      chk(av_write == 0 && av_read == 0 && busy_o == 0, "R11", "bus idle after reset",
          {av_write, av_read, busy_o}, 0);

      // single channel: every channel pattern x busy count x limit
      for (int c = 0; c < 4; c++)
         for (int p = 0; p < 4; p++)
            for (int l = 0; l < 4; l++)
               run_check(chans[c], 1'b0, l, p);

      // R7: random stalls on every transfer
      stall_en = 1;
      for (int p = 0; p < 3; p++) run_check(77, 1'b0, 2, p);
      // R6: sweep of all interfaces
      for (int p = 0; p < 3; p++) run_check(0, 1'b1, 2, p);
      stall_en = 0;
      run_check(0, 1'b1, 0, 0);
      // R8: timeout in a sweep stops at the first channel
      run_check(0, 1'b1, 2, 5);

      // R10: restart attempt while busy is ignored
      launch(5, 1'b0, 7, 3);
      repeat (3) @(negedge clk);
      start_i = 1; sweep_i = 1; chan_i = 10'd9;
      @(negedge clk);
      start_i = 0;
      await_done();
      chk(nw == 8, "R10", "writes after ignored start", nw, 8);
      chk(log_d[0] == 32'd5, "R10", "channel kept", log_d[0], 5);
      chk(ndone == 1, "R10", "single done", ndone, 1);
      repeat (20) @(negedge clk);
      #3;
      chk(nw == 8 && busy_o == 0, "R10", "no second run", nw, 8);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule